// File: doc/BRIEF.md
# DRAM Bank Open-Row Tracker

This block follows a decoded DRAM command stream and keeps a model of which of the four banks has a row open, and which row that is. Commands are taken on the rising clock edge. A command counts only when chip select is low and clock enable is high. The block handles several ways a bank can close:

- a precharge aimed at one bank;
- a precharge of every bank at once, chosen by address bit 10;
- a self-timed close that follows a read or write issued with auto-precharge.

From clock enable and the bank state, it also works out which low-power state the device has entered. It raises a sticky error flag when the stream breaks the open/closed rules, refreshes while a row is open, or drops clock enable during a burst.

A memory controller or a protocol monitor uses the outputs to see bank state and to catch sequencing bugs. Timing checks between commands and the data path are out of scope.

Top module: `bank_tracker`

## Requirements
- R1: When `csN` is high at a rising edge, the command has no effect: no bank changes state and no error is raised.
- R2: When `cke` is low at a rising edge, the command is ignored. `cke` low never opens or closes a bank.
- R3: An activate (cmd 1) opens the bank selected by `bankAddr`. It stores `addr[12:0]` as that bank's row in `openRows[b*13 +: 13]`. Both outputs update at the next edge.
- R4: A precharge (cmd 4) closes only the addressed bank when `addr[10]` is 0, and closes all four banks when `addr[10]` is 1.
- R5: Take a read (cmd 2) or write (cmd 3) with `addr[10]` = 1 to an open bank, registered at edge T. That bank closes at edge T+N, where N is half the burst length. The burst length is set by a mode set (cmd 6) with `bankAddr` = 0, using `addr[2:0]`: code 1 gives 2, code 2 gives 4, code 3 gives 8. Other codes, and mode sets with `bankAddr` other than 0, leave it unchanged. After reset the burst length is 8.
- R6: A read or write with `addr[10]` = 0 leaves the bank open.
- R7: `pwrState` uses this encoding: 0 = running, 1 = power-down with all banks idle, 2 = power-down with a row open. From running, `cke` low enters 1 if no bank is open and 2 otherwise. `cke` high returns to 0 at that edge.
- R8: A read or write to a closed bank, or an activate to an open bank, sets `errFlag`.
- R9: A refresh (cmd 5) sets `errFlag` when any bank is open. With all banks idle it raises no error.
- R10: `cke` low at any edge within N edges after an accepted read or write sets `errFlag`.
- R11: Reset closes all banks, clears all rows, sets running state and clears `errFlag`. `errFlag` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands taken on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| cke | input | 1 | Clock enable |
| cmd | input | 3 | Decoded command: 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode set |
| bankAddr | input | 2 | Bank select |
| addr | input | 13 | Row, column, precharge-all / auto-precharge bit 10, mode code |
| bankOpen | output | 4 | One flag per bank, high while a row is open |
| openRows | output | 52 | Row held by each bank, 13 bits per bank |
| pwrState | output | 2 | Running / idle power-down / active power-down |
| errFlag | output | 1 | Sticky sequence error |

## Verification
Every output is registered. A command applied before edge T shows its effect on the outputs just after T. The bench drives on the falling edge, lets exactly one rising edge pass, and checks on the following falling edge. Auto-precharge closes are counted edge by edge. The bench checks the bank still open at T+N-1 and closed at T+N for burst lengths 8, 4 and 2. The clock-enable burst error is probed one edge inside the window and at its first legal edge.

// File: rtl/bank_tracker_pkg.sv
package bank_tracker_pkg;
  localparam int BA_W      = 2;
  localparam int NUM_BANKS = 1 << BA_W;
  localparam int ROW_W     = 13;
  localparam int CNT_W     = 3;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_RUN    = 2'd0,
    PWR_IDLEPD = 2'd1,
    PWR_ACTPD  = 2'd2
  } pwr_e;

  typedef struct packed {
    logic            act;
    logic            rw;
    logic            autoPre;
    logic            preOne;
    logic            preAll;
    logic [BA_W-1:0] bank;
  } strobe_t;
endpackage

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import bank_tracker_pkg::*;
#(
  parameter int AP_BIT = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 cke,
  input  logic [2:0]           cmd,
  input  logic [BA_W-1:0]      bankAddr,
  input  logic [ROW_W-1:0]     addr,
  input  logic [NUM_BANKS-1:0] bankOpen,
  output strobe_t              stb,
  output logic [CNT_W-1:0]     halfBurst,
  output logic [1:0]           pwrState,
  output logic                 errFlag
);
  logic             valid;
  logic             selOpen;
  logic             isRw;
  logic             errNow;
  logic [CNT_W-1:0] burstCnt;
  pwr_e             pwrQ;

  assign valid   = !csN && cke;
  assign selOpen = bankOpen[bankAddr];
  assign isRw    = (cmd == CMD_RD) || (cmd == CMD_WR);

  always_comb begin
    stb         = '0;
    stb.bank    = bankAddr;
    stb.autoPre = addr[AP_BIT];
    stb.act     = valid && (cmd == CMD_ACT) && !selOpen;
    stb.rw      = valid && isRw && selOpen;
    stb.preOne  = valid && (cmd == CMD_PRE) && !addr[AP_BIT];
    stb.preAll  = valid && (cmd == CMD_PRE) && addr[AP_BIT];
  end

  always_comb begin
    errNow = 1'b0;
    if (valid) begin
      if ((cmd == CMD_ACT) && selOpen) errNow = 1'b1;
      if (isRw && !selOpen)            errNow = 1'b1;
      if ((cmd == CMD_REF) && (|bankOpen)) errNow = 1'b1;
    end
    if (!cke && (burstCnt != '0)) errNow = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag   <= 1'b0;
      burstCnt  <= '0;
      halfBurst <= CNT_W'(4);
      pwrQ      <= PWR_RUN;
    end else begin
      errFlag <= errFlag | errNow;
      if (stb.rw) burstCnt <= halfBurst;
      else if (burstCnt != '0) burstCnt <= burstCnt - 1'b1;
      if (valid && (cmd == CMD_MRS) && (bankAddr == '0)) begin
        case (addr[2:0])
          3'd1:    halfBurst <= CNT_W'(1);
          3'd2:    halfBurst <= CNT_W'(2);
          3'd3:    halfBurst <= CNT_W'(4);
          default: halfBurst <= halfBurst;
        endcase
      end
      if (cke) pwrQ <= PWR_RUN;
      else if (pwrQ == PWR_RUN) pwrQ <= (|bankOpen) ? PWR_ACTPD : PWR_IDLEPD;
    end
  end

  assign pwrState = pwrQ;
endmodule

// File: rtl/bank_dpath.sv
module bank_dpath
  import bank_tracker_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    stb,
  input  logic [ROW_W-1:0]           addr,
  input  logic [CNT_W-1:0]           halfBurst,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] openRows
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             openQ;
    logic [ROW_W-1:0] rowQ;
    logic [CNT_W-1:0] apCnt;
    logic             hit;

    assign hit = (stb.bank == BA_W'(b));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        openQ <= 1'b0;
        rowQ  <= '0;
        apCnt <= '0;
      end else if (stb.preAll || (stb.preOne && hit)) begin
        openQ <= 1'b0;
        apCnt <= '0;
      end else if (stb.act && hit) begin
        openQ <= 1'b1;
        rowQ  <= addr;
      end else if (stb.rw && hit && stb.autoPre) begin
        apCnt <= halfBurst;
      end else if (apCnt == CNT_W'(1)) begin
        openQ <= 1'b0;
        apCnt <= '0;
      end else if (apCnt != '0) begin
        apCnt <= apCnt - 1'b1;
      end
    end

    assign bankOpen[b]                 = openQ;
    assign openRows[b*ROW_W +: ROW_W]  = rowQ;
  end
endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
  import bank_tracker_pkg::*;
#(
  parameter int AP_BIT = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       csN,
  input  logic                       cke,
  input  logic [2:0]                 cmd,
  input  logic [BA_W-1:0]            bankAddr,
  input  logic [ROW_W-1:0]           addr,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] openRows,
  output logic [1:0]                 pwrState,
  output logic                       errFlag
);
  strobe_t          stb;
  logic [CNT_W-1:0] halfBurst;

  bank_ctrl #(.AP_BIT(AP_BIT)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .cke(cke), .cmd(cmd),
    .bankAddr(bankAddr), .addr(addr), .bankOpen(bankOpen),
    .stb(stb), .halfBurst(halfBurst), .pwrState(pwrState), .errFlag(errFlag)
  );

  bank_dpath dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr), .halfBurst(halfBurst),
    .bankOpen(bankOpen), .openRows(openRows)
  );
endmodule

// File: rtl/bank_tracker_chk.sv
module bank_tracker_chk
  import bank_tracker_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       csN,
  input logic                       cke,
  input logic [2:0]                 cmd,
  input logic [BA_W-1:0]            bankAddr,
  input logic [ROW_W-1:0]           addr,
  input logic [NUM_BANKS-1:0]       bankOpen,
  input logic [1:0]                 pwrState,
  input logic                       errFlag
);
  AST_OPEN_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rstN)
    (|(bankOpen & ~$past(bankOpen))) |-> $past(!csN && cke && (cmd == CMD_ACT))); // R3

  AST_PRE_ALL_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && cke && (cmd == CMD_PRE) && addr[10]) |=> (bankOpen == '0)); // R4

  AST_PD_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    ((pwrState == PWR_RUN) && !cke) |=>
      (pwrState == ($past(|bankOpen) ? PWR_ACTPD : PWR_IDLEPD))); // R7

  AST_CKE_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    cke |=> (pwrState == PWR_RUN)); // R7

  AST_REF_OPEN_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && cke && (cmd == CMD_REF) && (|bankOpen)) |=> errFlag); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(errFlag) |-> errFlag); // R11

  AST_CKE_LOW_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !cke |=> (|(bankOpen & ~$past(bankOpen))) == 1'b0); // R2
endmodule

bind bank_tracker bank_tracker_chk chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .cke(cke), .cmd(cmd),
  .bankAddr(bankAddr), .addr(addr), .bankOpen(bankOpen),
  .pwrState(pwrState), .errFlag(errFlag)
);

// File: tb/bank_tracker_tb_top.sv
`timescale 1ns/1ps
module bank_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        cke = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  bankAddr = 2'd0;
  logic [12:0] addr = 13'd0;
  logic [3:0]  bankOpen;
  logic [51:0] openRows;
  logic [1:0]  pwrState;
  logic        errFlag;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  bank_tracker dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .cke(cke), .cmd(cmd),
    .bankAddr(bankAddr), .addr(addr), .bankOpen(bankOpen),
    .openRows(openRows), .pwrState(pwrState), .errFlag(errFlag)
  );

  // {csN, cke, cmd, bank, addr, expOpen, expPwr}
  localparam int NV = 14;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'd1, 2'd0, 13'h0123, 4'b0001, 2'd0},
    {1'b0, 1'b1, 3'd1, 2'd2, 13'h1ABC, 4'b0101, 2'd0},
    {1'b0, 1'b1, 3'd2, 2'd0, 13'h0005, 4'b0101, 2'd0},
    {1'b1, 1'b1, 3'd4, 2'd0, 13'h0400, 4'b0101, 2'd0},
    {1'b0, 1'b1, 3'd4, 2'd2, 13'h0000, 4'b0001, 2'd0},
    {1'b0, 1'b1, 3'd0, 2'd0, 13'h0000, 4'b0001, 2'd0},
    {1'b0, 1'b1, 3'd0, 2'd0, 13'h0000, 4'b0001, 2'd0},
    {1'b0, 1'b0, 3'd0, 2'd0, 13'h0000, 4'b0001, 2'd2},
    {1'b0, 1'b0, 3'd1, 2'd1, 13'h0000, 4'b0001, 2'd2},
    {1'b0, 1'b1, 3'd0, 2'd0, 13'h0000, 4'b0001, 2'd0},
    {1'b0, 1'b1, 3'd4, 2'd1, 13'h0400, 4'b0000, 2'd0},
    {1'b0, 1'b0, 3'd0, 2'd0, 13'h0000, 4'b0000, 2'd1},
    {1'b0, 1'b1, 3'd0, 2'd0, 13'h0000, 4'b0000, 2'd0},
    {1'b0, 1'b1, 3'd5, 2'd0, 13'h0000, 4'b0000, 2'd0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic k, input logic [2:0] cm,
                      input logic [1:0] b, input logic [12:0] a);
    csN = c; cke = k; cmd = cm; bankAddr = b; addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nop();
    step(1'b0, 1'b1, 3'd0, 2'd0, 13'd0);
  endtask

  task automatic resetDut();
    rstN = 1'b0; csN = 1'b1; cke = 1'b1; cmd = 3'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    resetDut();
    check("R11 reset open", 64'(bankOpen), 64'h0);
    check("R11 reset rows", 64'(openRows), 64'h0);
    check("R11 reset pwr", 64'(pwrState), 64'h0);
    check("R11 reset err", 64'(errFlag), 64'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][25], VEC[i][24], VEC[i][23:21], VEC[i][20:19], VEC[i][18:6]);
      check($sformatf("table %0d R1 R2 R3 R4 R6 open", i), 64'(bankOpen), 64'(VEC[i][5:2]));
      check($sformatf("table %0d R7 pwr", i), 64'(pwrState), 64'(VEC[i][1:0]));
      check($sformatf("table %0d R9 err", i), 64'(errFlag), 64'h0);
    end

    // R3 row capture, R5 auto-precharge at burst 8 (N=4)
    resetDut();
    step(1'b0, 1'b1, 3'd1, 2'd3, 13'h1F0F);
    check("R3 open", 64'(bankOpen), 64'h8);
    check("R3 row", 64'(openRows[51:39]), 64'h1F0F);
    step(1'b0, 1'b1, 3'd2, 2'd3, 13'h0407);
    check("R5 bl8 T", 64'(bankOpen), 64'h8);
    nop(); check("R5 bl8 T+1", 64'(bankOpen), 64'h8);
    nop(); check("R5 bl8 T+2", 64'(bankOpen), 64'h8);
    nop(); check("R5 bl8 T+3", 64'(bankOpen), 64'h8);
    nop(); check("R5 bl8 T+4", 64'(bankOpen), 64'h0);

    // R5 burst 4, a mode set to bank 1 must not change it
    step(1'b0, 1'b1, 3'd6, 2'd0, 13'd2);
    step(1'b0, 1'b1, 3'd6, 2'd1, 13'd1);
    step(1'b0, 1'b1, 3'd1, 2'd1, 13'h0005);
    step(1'b0, 1'b1, 3'd3, 2'd1, 13'h0400);
    check("R5 bl4 T", 64'(bankOpen), 64'h2);
    nop(); check("R5 bl4 T+1", 64'(bankOpen), 64'h2);
    nop(); check("R5 bl4 T+2", 64'(bankOpen), 64'h0);

    // R5 burst 2
    step(1'b0, 1'b1, 3'd6, 2'd0, 13'd1);
    step(1'b0, 1'b1, 3'd1, 2'd0, 13'h0077);
    step(1'b0, 1'b1, 3'd3, 2'd0, 13'h0400);
    check("R5 bl2 T", 64'(bankOpen), 64'h1);
    nop(); check("R5 bl2 T+1", 64'(bankOpen), 64'h0);
    check("R5 no err", 64'(errFlag), 64'h0);

    // R8 activate to open bank
    resetDut();
    step(1'b0, 1'b1, 3'd1, 2'd0, 13'h0001);
    step(1'b0, 1'b1, 3'd1, 2'd0, 13'h0002);
    check("R8 act open", 64'(errFlag), 64'h1);

    // R8 read to closed bank
    resetDut();
    step(1'b0, 1'b1, 3'd2, 2'd2, 13'h0000);
    check("R8 rd closed", 64'(errFlag), 64'h1);

    // R1 deselected read to closed bank, R9 refresh with open row, R11 sticky
    resetDut();
    step(1'b1, 1'b1, 3'd2, 2'd2, 13'h0000);
    check("R1 cs high no err", 64'(errFlag), 64'h0);
    step(1'b0, 1'b1, 3'd1, 2'd1, 13'h0003);
    step(1'b0, 1'b1, 3'd5, 2'd0, 13'h0000);
    check("R9 ref open", 64'(errFlag), 64'h1);
    nop(); nop();
    check("R11 sticky", 64'(errFlag), 64'h1);
    resetDut();
    check("R11 cleared", 64'(errFlag), 64'h0);

    // R10 cke low inside burst window
    step(1'b0, 1'b1, 3'd1, 2'd0, 13'h0009);
    step(1'b0, 1'b1, 3'd2, 2'd0, 13'h0000);
    nop(); nop(); nop();
    step(1'b0, 1'b0, 3'd0, 2'd0, 13'h0000);
    check("R10 cke low in burst", 64'(errFlag), 64'h1);

    // R10 cke low just after window ends
    resetDut();
    step(1'b0, 1'b1, 3'd1, 2'd0, 13'h0009);
    step(1'b0, 1'b1, 3'd2, 2'd0, 13'h0000);
    nop(); nop(); nop(); nop();
    step(1'b0, 1'b0, 3'd0, 2'd0, 13'h0000);
    check("R10 cke low after burst", 64'(errFlag), 64'h0);
    check("R7 active pd", 64'(pwrState), 64'h2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule